// File: doc/BRIEF.md
# Pointer-Addressed Packet Data Port

This block gives a host processor a window into packet buffer memory. The host first sets a pointer register. It can do this with one 16-bit write, or with two byte writes that commit as a pair. It then moves buffer data through a data register, either one byte or one word at a time. Host reads are served from a small read-ahead queue. That queue is emptied and refilled from memory each time the pointer changes. A ready flag tells the host when read data can be trusted: a programmable settling time has to pass after each pointer load, and the queue must hold at least one word.

An auto-increment bit sits in the pointer register. When it is set, every data access moves the pointer forward, so the host can stream a packet in or out. When it is clear, the pointer stays where it is and has to be even. An odd value raises an error flag. Data writes go straight to memory and discard any read-ahead contents, so stale data can never be returned.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the pointer and the auto-increment bit are zero, the queue is empty and `dataReady` is low.
- R2: A write to offset 6 with both byte enables loads the pointer from `hostWdata[PTR_W-1:0]` and auto-increment from `hostWdata[14]`. A read of offset 6 returns the pointer in bits `[PTR_W-1:0]` and auto-increment in bit 14, with zeros elsewhere.
- R3: A write to offset 6 with enable `01` only stages the low byte, and the pointer does not change. A write with enable `10` then commits the pointer `{hostWdata[15:8], staged byte}` together with auto-increment from `hostWdata[14]`.
- R4: After a pointer commit, `dataReady` stays low for exactly `FILL_CYCLES` clock cycles. It rises once that count has run out and the queue holds at least one word.
- R5: A data read at offset 8 or 10 with `dataReady` high returns its result on `hostRdata` in the next cycle. A word read (enable `11`) returns the word at address `pointer>>1`. A byte read (enable `01` or `10`) returns byte `pointer[0]` of that word (0 means bits 7:0), copied into both lanes.
- R6: A data read while `dataReady` is low returns zero and leaves the pointer unchanged.
- R7: With auto-increment set, each accepted data access advances the pointer by 1 for a byte access and by 2 for a word access. Consecutive reads return consecutive buffer data.
- R8: With auto-increment clear, data accesses leave the pointer unchanged, and repeated reads return the same data.
- R9: `ptrOddErr` is high exactly when auto-increment is clear and the pointer is odd.
- R10: A data write puts a word write (enable `11`) at address `pointer>>1` onto the memory port in the same cycle. A byte write writes the byte from the host lane it selects into byte `pointer[0]` of that word.
- R11: A data write discards all read-ahead data, so a later read of the written location returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostAddr | input | 4 | Register byte offset (6 pointer, 8 and 10 data) |
| hostBe | input | 2 | Host byte enables |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 16 | Host write data |
| hostRdata | output | 16 | Registered host read data |
| memEn | output | 1 | Memory access enable |
| memWe | output | 1 | Memory write enable |
| memAddr | output | PTR_W-1 | Memory word address |
| memBe | output | 2 | Memory byte write enables |
| memWdata | output | 16 | Memory write data |
| memRdata | input | 16 | Memory read data, one cycle after the request |
| dataReady | output | 1 | Read-ahead data is valid |
| ptrOddErr | output | 1 | Odd pointer while auto-increment is clear |

## Verification
The bench builds the block with `DEPTH=2` and `FILL_CYCLES=5`. The shallow queue fills after two fetches, so full-queue stalls and index wrap-around occur in every short streaming read. The short settling count lets the bench test the exact cycle at which ready rises after each pointer load, and it keeps the many reloads the test needs cheap. `PTR_W` stays at 11, so the pointer wraps inside a 1024-word buffer.

// File: rtl/pkt_port_pkg.sv
package pkt_port_pkg;
  localparam logic [3:0] PTR_OFS     = 4'h6;
  localparam logic [3:0] DATA_OFS_LO = 4'h8;
  localparam logic [3:0] DATA_OFS_HI = 4'hA;
  localparam int         AUTO_BIT    = 14;

  typedef struct packed {
    logic flush;   // drop queued and in-flight read-ahead data
    logic issue;   // launch one read-ahead fetch
    logic pop;     // retire queue head
    logic memWr;   // host data write owns the memory port
  } portStrobe_t;
endpackage

// File: rtl/pkt_port_ctrl.sv
module pkt_port_ctrl
  import pkt_port_pkg::*;
#(
  parameter int PTR_W       = 11,
  parameter int FILL_CYCLES = 80,
  parameter int DEPTH       = 4,
  localparam int CNT_W      = $clog2(DEPTH + 1),
  localparam int TMR_W      = $clog2(FILL_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        hostAddr,
  input  logic [1:0]        hostBe,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              inflight,
  input  logic [15:0]       head,
  output portStrobe_t       strb,
  output logic [PTR_W-2:0]  fetchBase,
  output logic [PTR_W-2:0]  ptrWord,
  output logic [15:0]       memWdata,
  output logic [1:0]        memBe,
  output logic              dataReady,
  output logic              ptrOddErr
);
  logic [PTR_W-1:0] ptr, ptrNext, ptrAdv, newPtr;
  logic             autoInc;
  logic [7:0]       lowStage;
  logic [TMR_W-1:0] timer;
  logic [15:0]      hiVal, ptrView, dataVal;
  logic [7:0]       wrByte, rdByte;
  logic isPtr, isData, wordAcc, ptrWordWr, ptrLowWr, ptrHighWr, commit;
  logic dataWr, dataRd, rdAccept, step;

  always_comb begin
    isPtr     = (hostAddr == PTR_OFS);
    isData    = (hostAddr == DATA_OFS_LO) || (hostAddr == DATA_OFS_HI);
    wordAcc   = (hostBe == 2'b11);
    ptrWordWr = hostWr && isPtr && wordAcc;
    ptrLowWr  = hostWr && isPtr && (hostBe == 2'b01);
    ptrHighWr = hostWr && isPtr && (hostBe == 2'b10);
    commit    = ptrWordWr || ptrHighWr;
    dataWr    = hostWr && isData && (hostBe != 2'b00);
    dataRd    = hostRd && !hostWr && isData && (hostBe != 2'b00);
    dataReady = (timer == '0) && (count != '0);
    rdAccept  = dataRd && dataReady;
    step      = (dataWr || rdAccept) && autoInc;

    hiVal   = {hostWdata[15:8], lowStage};
    newPtr  = ptrWordWr ? hostWdata[PTR_W-1:0] : hiVal[PTR_W-1:0];
    ptrAdv  = ptr + (wordAcc ? PTR_W'(2) : PTR_W'(1));
    ptrNext = commit ? newPtr : (step ? ptrAdv : ptr);

    strb.flush = commit || dataWr;
    strb.memWr = dataWr;
    strb.pop   = rdAccept && autoInc && (ptrAdv[PTR_W-1:1] != ptr[PTR_W-1:1]);
    strb.issue = !strb.flush && ((int'(count) + int'(inflight)) < DEPTH);

    fetchBase = ptrNext[PTR_W-1:1];
    ptrWord   = ptr[PTR_W-1:1];
    wrByte    = hostBe[1] ? hostWdata[15:8] : hostWdata[7:0];
    memWdata  = wordAcc ? hostWdata : {wrByte, wrByte};
    memBe     = wordAcc ? 2'b11 : (ptr[0] ? 2'b10 : 2'b01);

    rdByte  = ptr[0] ? head[15:8] : head[7:0];
    dataVal = wordAcc ? head : {rdByte, rdByte};
    ptrView = '0;
    ptrView[PTR_W-1:0] = ptr;
    ptrView[AUTO_BIT]  = autoInc;
    ptrOddErr = !autoInc && ptr[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr       <= '0;
      autoInc   <= 1'b0;
      lowStage  <= '0;
      timer     <= TMR_W'(FILL_CYCLES);
      hostRdata <= '0;
    end else begin
      ptr <= ptrNext;
      if (commit) autoInc <= hostWdata[AUTO_BIT];
      if (ptrLowWr) lowStage <= hostWdata[7:0];
      if (commit) timer <= TMR_W'(FILL_CYCLES);
      else if (timer != '0) timer <= timer - 1'b1;
      if (hostRd && !hostWr) begin
        if (isData) hostRdata <= rdAccept ? dataVal : 16'h0000;
        else if (isPtr) hostRdata <= ptrView;
        else hostRdata <= 16'h0000;
      end
    end
  end
endmodule

// File: rtl/pkt_port_dpath.sv
module pkt_port_dpath
  import pkt_port_pkg::*;
#(
  parameter int PTR_W  = 11,
  parameter int DEPTH  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  portStrobe_t       strb,
  input  logic [PTR_W-2:0]  fetchBase,
  input  logic [PTR_W-2:0]  ptrWord,
  input  logic [15:0]       memRdata,
  output logic              memEn,
  output logic              memWe,
  output logic [PTR_W-2:0]  memAddr,
  output logic [CNT_W-1:0]  count,
  output logic              inflight,
  output logic [15:0]       head
);
  logic [15:0]      store [DEPTH];
  logic [IDX_W-1:0] wrIdx, rdIdx;
  logic [PTR_W-2:0] fetchAddr;
  logic             push;

  function automatic logic [IDX_W-1:0] bump(input logic [IDX_W-1:0] idx);
    return (int'(idx) == DEPTH - 1) ? '0 : idx + 1'b1;
  endfunction

  always_comb begin
    push    = inflight && !strb.flush;
    memEn   = strb.memWr || strb.issue;
    memWe   = strb.memWr;
    memAddr = strb.memWr ? ptrWord : fetchAddr;
    head    = store[rdIdx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      wrIdx     <= '0;
      rdIdx     <= '0;
      inflight  <= 1'b0;
      fetchAddr <= '0;
    end else if (strb.flush) begin
      count     <= '0;
      wrIdx     <= '0;
      rdIdx     <= '0;
      inflight  <= 1'b0;
      fetchAddr <= fetchBase;
    end else begin
      if (push) wrIdx <= bump(wrIdx);
      if (strb.pop) rdIdx <= bump(rdIdx);
      count    <= count + CNT_W'(push) - CNT_W'(strb.pop);
      inflight <= strb.issue;
      if (strb.issue) fetchAddr <= fetchAddr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wrIdx] <= memRdata;
  end
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
  import pkt_port_pkg::*;
#(
  parameter int PTR_W       = 11,
  parameter int FILL_CYCLES = 80,
  parameter int DEPTH       = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       hostAddr,
  input  logic [1:0]       hostBe,
  input  logic             hostWr,
  input  logic             hostRd,
  input  logic [15:0]      hostWdata,
  output logic [15:0]      hostRdata,
  output logic             memEn,
  output logic             memWe,
  output logic [PTR_W-2:0] memAddr,
  output logic [1:0]       memBe,
  output logic [15:0]      memWdata,
  input  logic [15:0]      memRdata,
  output logic             dataReady,
  output logic             ptrOddErr
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  portStrobe_t      strb;
  logic [CNT_W-1:0] count;
  logic             inflight;
  logic [15:0]      head;
  logic [PTR_W-2:0] fetchBase, ptrWord;

  pkt_port_ctrl #(.PTR_W(PTR_W), .FILL_CYCLES(FILL_CYCLES), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostBe(hostBe), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata), .count(count),
    .inflight(inflight), .head(head), .strb(strb), .fetchBase(fetchBase),
    .ptrWord(ptrWord), .memWdata(memWdata), .memBe(memBe), .dataReady(dataReady),
    .ptrOddErr(ptrOddErr)
  );

  pkt_port_dpath #(.PTR_W(PTR_W), .DEPTH(DEPTH)) u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .fetchBase(fetchBase), .ptrWord(ptrWord),
    .memRdata(memRdata), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .count(count), .inflight(inflight), .head(head)
  );
endmodule

// File: rtl/pkt_data_port_chk.sv
module pkt_data_port_chk
  import pkt_port_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [3:0]  hostAddr,
  input logic [1:0]  hostBe,
  input logic        hostWr,
  input logic        hostRd,
  input logic [15:0] hostWdata,
  input logic [15:0] hostRdata,
  input logic        memEn,
  input logic        memWe,
  input logic        dataReady,
  input logic        ptrOddErr
);
  logic isData;
  assign isData = (hostAddr == DATA_OFS_LO) || (hostAddr == DATA_OFS_HI);

  assert_load_hides_ready_R4: assert property (@(posedge clk) disable iff (rst)
    (hostWr && hostAddr == PTR_OFS && (hostBe == 2'b11 || hostBe == 2'b10)) |=> !dataReady);

  assert_odd_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (hostWr && hostAddr == PTR_OFS && hostBe == 2'b11 && !hostWdata[AUTO_BIT] && hostWdata[0])
      |=> ptrOddErr);

  assert_early_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (hostRd && !hostWr && isData && !dataReady) |=> (hostRdata == 16'h0000));

  assert_write_reaches_mem_R10: assert property (@(posedge clk) disable iff (rst)
    (hostWr && isData && hostBe != 2'b00) |-> (memEn && memWe));

  assert_low_stage_holds_R3: assert property (@(posedge clk) disable iff (rst)
    (hostWr && hostAddr == PTR_OFS && hostBe == 2'b01) |=> $stable(ptrOddErr));
endmodule

bind pkt_data_port pkt_data_port_chk u_chk (
  .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostBe(hostBe), .hostWr(hostWr),
  .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata), .memEn(memEn),
  .memWe(memWe), .dataReady(dataReady), .ptrOddErr(ptrOddErr)
);

// File: tb/pkt_data_port_bench.sv
`timescale 1ns/1ps
module pkt_data_port_bench;
  localparam int PTR_W = 11;
  localparam int FILL  = 5;
  localparam int DEPTH = 2;
  localparam int WORDS = 1 << (PTR_W - 1);
  localparam int PMASK = (1 << PTR_W) - 1;

  logic clk = 0, rst = 1;
  logic [3:0] hostAddr = 0;
  logic [1:0] hostBe = 0;
  logic hostWr = 0, hostRd = 0;
  logic [15:0] hostWdata = 0, hostRdata, memWdata, memRdata;
  logic memEn, memWe, dataReady, ptrOddErr;
  logic [PTR_W-2:0] memAddr;
  logic [1:0] memBe;

  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pkt_data_port #(.PTR_W(PTR_W), .FILL_CYCLES(FILL), .DEPTH(DEPTH)) u_pkt_data_port (
    .clk(clk), .rst(rst), .hostAddr(hostAddr), .hostBe(hostBe), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata), .memEn(memEn),
    .memWe(memWe), .memAddr(memAddr), .memBe(memBe), .memWdata(memWdata),
    .memRdata(memRdata), .dataReady(dataReady), .ptrOddErr(ptrOddErr)
  );

  function automatic logic [15:0] initVal(input int i);
    return 16'((i * 257) ^ 16'h5A3C);
  endfunction

  // buffer memory seen by the design
  logic [15:0] mem [WORDS];
  logic [15:0] memQ = 0;
  assign memRdata = memQ;
  initial for (int i = 0; i < WORDS; i++) mem[i] = initVal(i);
  always @(posedge clk) if (memEn) begin
    if (memWe) begin
      if (memBe[0]) mem[memAddr][7:0]  <= memWdata[7:0];
      if (memBe[1]) mem[memAddr][15:8] <= memWdata[15:8];
    end else memQ <= mem[memAddr];
  end

  // behavioural reference model
  logic [15:0] refMem [WORDS];
  initial for (int i = 0; i < WORDS; i++) refMem[i] = initVal(i);
  logic [15:0] q[$];
  int mPtr = 0, mTimer = FILL, mFetch = 0;
  bit mAuto = 0, mInf = 0;
  logic [7:0] mLow = 0;
  logic [15:0] mInfData = 0, mRd = 0;

  always @(posedge clk) begin
    bit isP, isD, word, pw, pl, ph, com, dw, dr, rdy, acc, flush, iss, pop;
    int nxt, adv;
    logic [15:0] hd;
    logic [7:0] b;
    if (rst) begin
      mPtr = 0; mAuto = 0; mLow = 0; mTimer = FILL; q.delete();
      mInf = 0; mFetch = 0; mRd = 0;
    end else begin
      isP = (hostAddr == 4'h6);
      isD = (hostAddr == 4'h8) || (hostAddr == 4'hA);
      word = (hostBe == 2'b11);
      pw = hostWr && isP && word;
      pl = hostWr && isP && hostBe == 2'b01;
      ph = hostWr && isP && hostBe == 2'b10;
      com = pw || ph;
      dw = hostWr && isD && hostBe != 0;
      dr = hostRd && !hostWr && isD && hostBe != 0;
      rdy = (mTimer == 0) && (q.size() != 0);
      acc = dw || (dr && rdy);
      adv = (mPtr + (word ? 2 : 1)) & PMASK;
      nxt = com ? (pw ? (hostWdata & PMASK) : ({hostWdata[15:8], mLow} & PMASK))
                : ((acc && mAuto) ? adv : mPtr);
      pop = dr && rdy && mAuto && ((adv >> 1) != (mPtr >> 1));
      flush = com || dw;
      iss = !flush && (q.size() + mInf < DEPTH);
      hd = (q.size() != 0) ? q[0] : 16'h0;
      if (hostRd && !hostWr) begin
        if (isD) begin
          b = mPtr[0] ? hd[15:8] : hd[7:0];
          mRd = (dr && rdy) ? (word ? hd : {b, b}) : 16'h0;
        end else if (isP) mRd = 16'((mAuto ? 16'h4000 : 16'h0) | mPtr);
        else mRd = 0;
      end
      if (dw) begin
        b = hostBe[1] ? hostWdata[15:8] : hostWdata[7:0];
        if (word) refMem[mPtr >> 1] = hostWdata;
        else if (mPtr[0]) refMem[mPtr >> 1][15:8] = b;
        else refMem[mPtr >> 1][7:0] = b;
      end
      if (flush) begin
        q.delete(); mInf = 0; mFetch = nxt >> 1;
      end else begin
        if (pop) void'(q.pop_front());
        if (mInf) q.push_back(mInfData);
        if (iss) begin mInfData = refMem[mFetch]; mFetch = (mFetch + 1) % WORDS; end
        mInf = iss;
      end
      if (pl) mLow = hostWdata[7:0];
      if (com) mAuto = hostWdata[14];
      if (com) mTimer = FILL; else if (mTimer > 0) mTimer--;
      mPtr = nxt;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) if (!rst && !done) begin
    check(hostRdata == mRd, "R5/R6 hostRdata", hostRdata, mRd);
    check(dataReady == ((mTimer == 0) && (q.size() != 0)), "R4 dataReady",
          dataReady, (mTimer == 0) && (q.size() != 0));
    check(ptrOddErr == (!mAuto && mPtr[0]), "R9 ptrOddErr", ptrOddErr, !mAuto && mPtr[0]);
  end

  task automatic wr(input logic [3:0] a, input logic [1:0] be, input logic [15:0] d);
    hostAddr = a; hostBe = be; hostWdata = d; hostWr = 1;
    @(negedge clk);
    hostWr = 0; hostBe = 0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] be, output logic [15:0] v);
    hostAddr = a; hostBe = be; hostRd = 1;
    @(negedge clk);
    hostRd = 0; hostBe = 0;
    v = hostRdata;
  endtask

  task automatic waitReady();
    int guard = 0;
    while (!dataReady && guard < 200) begin @(negedge clk); guard++; end
  endtask

  task automatic rdReady(input logic [1:0] be, output logic [15:0] v);
    waitReady();
    rd(4'h8, be, v);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    check(dataReady == 0, "R1 ready after reset", dataReady, 0);
    rd(4'h6, 2'b11, v);
    check(v == 16'h0000, "R1 pointer after reset", v, 0);

    // R2 word pointer load and readback, R4 exact fill time
    wr(4'h6, 2'b11, 16'h4010);
    cnt = 0;
    while (!dataReady && cnt < 100) begin @(negedge clk); cnt++; end
    check(cnt == FILL, "R4 cycles until ready", cnt, FILL);
    rd(4'h6, 2'b11, v);
    check(v == 16'h4010, "R2 pointer readback", v, 16'h4010);

    // R5 R7 streaming word reads
    for (int i = 0; i < 6; i++) begin
      rdReady(2'b11, v);
      check(v == initVal(8 + i), "R5 R7 streamed word", v, initVal(8 + i));
    end
    rd(4'h6, 2'b11, v);
    check(v == 16'h401C, "R7 pointer after word reads", v, 16'h401C);

    // R5 R7 byte reads from an odd pointer
    wr(4'h6, 2'b11, 16'h4021);
    rdReady(2'b01, v);
    check(v == {initVal(16)[15:8], initVal(16)[15:8]}, "R5 odd byte read", v,
          {initVal(16)[15:8], initVal(16)[15:8]});
    rdReady(2'b10, v);
    check(v == {initVal(17)[7:0], initVal(17)[7:0]}, "R5 R7 even byte read", v,
          {initVal(17)[7:0], initVal(17)[7:0]});
    rd(4'h6, 2'b11, v);
    check(v == 16'h4023, "R7 pointer after byte reads", v, 16'h4023);

    // R8 fixed pointer
    wr(4'h6, 2'b11, 16'h0030);
    rdReady(2'b11, v);
    check(v == initVal(24), "R8 first read", v, initVal(24));
    rdReady(2'b11, v);
    check(v == initVal(24), "R8 repeated read", v, initVal(24));
    rd(4'h6, 2'b11, v);
    check(v == 16'h0030, "R8 pointer unchanged", v, 16'h0030);

    // R9 odd pointer flag
    wr(4'h6, 2'b11, 16'h0031);
    check(ptrOddErr == 1, "R9 odd fixed pointer", ptrOddErr, 1);
    wr(4'h6, 2'b11, 16'h4031);
    check(ptrOddErr == 0, "R9 odd auto pointer", ptrOddErr, 0);

    // R3 byte-wise pointer load
    wr(4'h6, 2'b01, 16'h0055);
    rd(4'h6, 2'b11, v);
    check(v == 16'h4031, "R3 low byte only staged", v, 16'h4031);
    wr(4'h6, 2'b10, 16'h4200);
    rd(4'h6, 2'b11, v);
    check(v == 16'h4255, "R3 high byte commits", v, 16'h4255);

    // R6 read before ready
    wr(4'h6, 2'b11, 16'h4060);
    rd(4'h8, 2'b11, v);
    check(v == 16'h0000, "R6 early read data", v, 0);
    rd(4'h6, 2'b11, v);
    check(v == 16'h4060, "R6 pointer not advanced", v, 16'h4060);

    // R11 R10 write invalidates read-ahead
    wr(4'h6, 2'b11, 16'h0040);
    rdReady(2'b11, v);
    check(v == initVal(32), "R11 prefetched value", v, initVal(32));
    wr(4'hA, 2'b11, 16'hBEEF);
    rdReady(2'b11, v);
    check(v == 16'hBEEF, "R11 R10 read after write", v, 16'hBEEF);
    wr(4'h6, 2'b11, 16'h4041);
    wr(4'h8, 2'b10, 16'h7700);
    wr(4'h6, 2'b11, 16'h0040);
    rdReady(2'b11, v);
    check(v == 16'h77EF, "R10 byte write lane", v, 16'h77EF);

    // R7 R10 auto-increment write stream
    wr(4'h6, 2'b11, 16'h4050);
    for (int i = 0; i < 3; i++) wr(4'h8, 2'b11, 16'hC000 + 16'(i));
    rd(4'h6, 2'b11, v);
    check(v == 16'h4056, "R7 pointer after writes", v, 16'h4056);
    wr(4'h6, 2'b11, 16'h4050);
    for (int i = 0; i < 3; i++) begin
      rdReady(2'b11, v);
      check(v == 16'hC000 + 16'(i), "R10 written stream", v, 16'hC000 + 16'(i));
    end

    // R1 reset mid-run
    rst = 1;
    @(negedge clk);
    rst = 0;
    check(dataReady == 0, "R1 ready after second reset", dataReady, 0);
    rd(4'h6, 2'b11, v);
    check(v == 16'h0000, "R1 pointer after second reset", v, 0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule